// File: doc/BRIEF.md
# Reference Source Selector with Phase-Slope Limit Control

This block picks one of three reference clock sources for a frequency-translating PLL from a two-bit select input. It reports the chosen source to the clock multiplexer in two forms: a one-hot vector and a two-bit code. When the chosen source changes, it raises a single-cycle update strobe. This strobe stands in for the glitch-free handover handshake of the real multiplexer.

The block also drives a phase-slope-limit enable toward the phase detector. The enable is high whenever the manual limit pin is high. It also goes high on its own for a fixed number of system clock cycles each time the active source changes. A further change during that window starts the window again from its full length.

All pins are asynchronous to the system clock, so each is resynchronised before use. Reset leaves differential source 0 active with limiting off. Reset does not start a window.

Top module: `refsel_slope_ctrl`

## Requirements
- R1: Select code 00 makes differential source 0 active: src_code = 0 and src_onehot = 3'b001.
- R2: Select code 01 makes differential source 1 active: src_code = 1 and src_onehot = 3'b010.
- R3: Select codes 10 and 11 both make the single-ended source active: src_code = 2 and src_onehot = 3'b100. The lower select bit is ignored, so moving between 10 and 11 gives no update strobe and no limit window.
- R4: src_onehot always has exactly one bit set, at bit position src_code.
- R5: A change of the select pins reaches src_code on the third rising clock edge after the pins settle (two synchroniser flops, then the active register). sel_update is high for exactly that one cycle, and only when the active source actually changes.
- R6: From the cycle in which the active source changes, limit_en stays high for exactly WINDOW_CYCLES cycles, unless the manual pin also holds it high.
- R7: A source change during a running window reloads the window to the full WINDOW_CYCLES, counted from the new change.
- R8: The manual limit pin, after a two-flop synchroniser, forces limit_en high, with a latency of two rising edges. limit_en follows the pin back low when no window is running.
- R9: During and after reset, src_code = 0, src_onehot = 3'b001, sel_update = 0 and limit_en = 0. Reset starts no window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_pins | input | 2 | Source select pins, asynchronous |
| manual_limit | input | 1 | Manual phase-slope-limit request, asynchronous |
| src_onehot | output | 3 | One-hot active source: bit0 diff 0, bit1 diff 1, bit2 single-ended |
| src_code | output | 2 | Encoded active source: 0, 1 or 2 |
| sel_update | output | 1 | One-cycle strobe when the active source changes |
| limit_en | output | 1 | Phase-slope-limit enable toward the phase detector |

## Verification
The bench builds the block with WINDOW_CYCLES = 16 and the default two synchroniser stages. With these values the exact end of a window is visible in a few dozen cycles. So is a restart triggered partway through a window. Both can be compared edge by edge against a cycle model of the requirements. The default window of 1024 would only stretch the same sequences without reaching any other state.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    SRC_DIFF0  = 2'd0,
    SRC_DIFF1  = 2'd1,
    SRC_SINGLE = 2'd2
  } src_t;

  localparam int unsigned NUM_SRC = 3;
endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= '0;
      else        stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rs_decode.sv
module rs_decode
  import rs_pkg::*;
(
  input  logic [1:0]         pins_sync,
  input  src_t               active,
  output src_t               wanted,
  output logic               differs,
  output logic [NUM_SRC-1:0] onehot
);
  logic [1:0] active_bits;

  // upper bit high selects the single-ended source; lower bit is a don't-care then
  always_comb begin
    if (pins_sync[1])      wanted = SRC_SINGLE;
    else if (pins_sync[0]) wanted = SRC_DIFF1;
    else                   wanted = SRC_DIFF0;
  end

  assign differs     = (wanted != active);
  assign active_bits = active;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_onehot
    assign onehot[i] = (active_bits == 2'(i));
  end
endmodule

// File: rtl/rs_window.sv
module rs_window #(
  parameter int unsigned WINDOW_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active_o
);
  localparam int unsigned CW = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(WINDOW_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign active_o = (cnt != '0);

  // R6: window ends only after the last counted cycle
  p_window_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_o) |-> ($past(cnt) == CW'(1) && !$past(start)));
endmodule

// File: rtl/refsel_slope_ctrl.sv
module refsel_slope_ctrl
  import rs_pkg::*;
#(
  parameter int unsigned WINDOW_CYCLES = 1024,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_pins,
  input  logic       manual_limit,
  output logic [2:0] src_onehot,
  output logic [1:0] src_code,
  output logic       sel_update,
  output logic       limit_en
);
  logic [1:0] sel_sync;
  logic       man_sync;
  src_t       active_q;
  src_t       wanted;
  logic       differs;
  logic       upd_q;
  logic       win_on;

  rs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sel_sync (
    .clk(clk), .rst_n(rst_n), .d(sel_pins), .q(sel_sync)
  );

  rs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_man_sync (
    .clk(clk), .rst_n(rst_n), .d(manual_limit), .q(man_sync)
  );

  rs_decode u_dec (
    .pins_sync(sel_sync), .active(active_q), .wanted(wanted),
    .differs(differs), .onehot(src_onehot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= SRC_DIFF0;
      upd_q    <= 1'b0;
    end else begin
      upd_q <= differs;
      if (differs) active_q <= wanted;
    end
  end

  rs_window #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_win (
    .clk(clk), .rst_n(rst_n), .start(differs), .active_o(win_on)
  );

  assign src_code   = active_q;
  assign sel_update = upd_q;
  assign limit_en   = man_sync | win_on;

  // R4: one-hot vector agrees with the code
  p_onehot_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    src_onehot == (3'b001 << src_code));

  // R5: the code moves only together with the update strobe
  p_code_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_update |-> $stable(src_code));

  // R6: a source change always shows a limiting window
  p_change_limits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_update |-> limit_en);

  // R3: the single-ended code is never left by a change of the lower pin alone
  p_low_bit_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_update && src_code == 2'd2) |-> ($past(src_code) != 2'd2));
endmodule

// File: tb/tb_refsel_slope_ctrl.sv
module tb_refsel_slope_ctrl;
  localparam int unsigned W = 16;

  typedef struct {
    logic [1:0] code;
    logic [2:0] onehot;
    logic       upd;
    logic       lim;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel_pins = 2'b00;
  logic       manual_limit = 1'b0;
  logic [2:0] src_onehot;
  logic [1:0] src_code;
  logic       sel_update;
  logic       limit_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t q[$];

  // cycle model of the requirements
  logic [1:0] m_p1 = 0, m_p2 = 0, m_act = 0;
  logic       m_m1 = 0, m_m2 = 0;
  int         m_rem = 0;

  always #10 clk = ~clk;

  refsel_slope_ctrl #(.WINDOW_CYCLES(W)) dut (
    .clk(clk), .rst_n(rst_n), .sel_pins(sel_pins), .manual_limit(manual_limit),
    .src_onehot(src_onehot), .src_code(src_code), .sel_update(sel_update),
    .limit_en(limit_en)
  );

  function automatic logic [1:0] dec(logic [1:0] p);
    return p[1] ? 2'd2 : (p[0] ? 2'd1 : 2'd0);
  endfunction

  task automatic chk(string tag, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
    end
  endtask

  // driver: applies pins, advances the model, pushes expectations
  task automatic run(logic [1:0] sel, logic man, int n, string tag);
    @(negedge clk);
    sel_pins = sel;
    manual_limit = man;
    for (int k = 0; k < n; k++) begin
      exp_t e;
      logic upd;
      @(posedge clk);
      upd = (dec(m_p2) != m_act);
      if (upd) begin
        m_act = dec(m_p2);
        m_rem = W;
      end else if (m_rem > 0) begin
        m_rem--;
      end
      m_p2 = m_p1; m_p1 = sel;
      m_m2 = m_m1; m_m1 = man;
      e.code   = m_act;
      e.onehot = 3'b001 << m_act;
      e.upd    = upd;
      e.lim    = m_m2 | (m_rem != 0);
      e.tag    = tag;
      q.push_back(e);
    end
  endtask

  // monitor: compares at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, "/R1-code"}, "src_code", src_code, e.code);
      chk({e.tag, "/R4"}, "src_onehot", src_onehot, e.onehot);
      chk({e.tag, "/R5"}, "sel_update", sel_update, e.upd);
      chk({e.tag, "/R6"}, "limit_en", limit_en, e.lim);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "src_code", src_code, 0);
    chk("R9", "src_onehot", src_onehot, 1);
    chk("R9", "sel_update", sel_update, 0);
    chk("R9", "limit_en", limit_en, 0);
    rst_n = 1'b1;
    run(2'b00, 1'b0, 8,  "R9");
    run(2'b01, 1'b0, 8,  "R2");
    run(2'b01, 1'b0, 20, "R6");
    run(2'b10, 1'b0, 24, "R3");
    run(2'b11, 1'b0, 20, "R3");
    run(2'b01, 1'b0, 10, "R7");
    run(2'b00, 1'b0, 24, "R7");
    run(2'b00, 1'b1, 6,  "R8");
    run(2'b00, 1'b0, 6,  "R8");
    run(2'b11, 1'b1, 12, "R8");
    run(2'b11, 1'b0, 24, "R6");
    run(2'b00, 1'b0, 24, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule